// File: doc/BRIEF.md
# Sampled Input Noise Filter

This block cleans up a slow external input pin before a capture unit or an interrupt path uses it. The raw pin first crosses into the system clock domain through a chain of synchronizing flops. The synchronized level is then sampled at a rate chosen by a 2-bit select. The filtered output moves to a new value only after a run of consecutive samples has agreed on that value. A built-in prescaler divides the system clock to make the sampling enables.

Select code 00 bypasses the filter, so the synchronized level passes straight to the output register. The other three codes sample on every clock, on every 8th clock or on every 32nd clock. Each change of the filtered level also raises a one-cycle strobe, either for a rising edge or for a falling edge, which a timer or an interrupt controller downstream can use directly. A change of the select code restarts the prescaler and discards the samples gathered so far.

Top module: `pin_glitch_filter`

## Requirements
- R1: The pin passes through two synchronizing flops before anything else uses it. In bypass mode a pin change reaches `level_o` on the third rising clock edge after the change.
- R2: With `rate_sel_i` = 2'b00 (bypass), `level_o` copies the synchronized pin on every clock with no agreement needed, so a pulse one clock wide passes through.
- R3: With `rate_sel_i` = 2'b01, one sample is taken every clock, and a steady pin change reaches `level_o` on the fifth rising edge after the change.
- R4: With `rate_sel_i` = 2'b10, one sample is taken every 8 clocks, starting 8 clocks after the select takes effect.
- R5: With `rate_sel_i` = 2'b11, one sample is taken every 32 clocks, starting 32 clocks after the select takes effect.
- R6: In the three sampling modes, `level_o` takes a new value only when three successive samples all hold that value. A pulse that spans fewer than three sample periods never reaches `level_o`.
- R7: `rise_o` is high for exactly the one clock in which `level_o` has just gone from 0 to 1, and `fall_o` likewise for 1 to 0. The two strobes are never high together.
- R8: While `rst_ni` is low, `level_o`, `rise_o` and `fall_o` are 0 and the sample history and the prescaler are cleared.
- R9: A change of `rate_sel_i` clears the prescaler count and the sample history on the next edge, and `level_o` holds its value during that edge. Three fresh samples are then needed before `level_o` can change.
- R10: In a sampling mode, `level_o` changes only on a clock edge where a sample is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rate_sel_i | input | 2 | Filter mode: 00 bypass, 01 every clock, 10 every 8 clocks, 11 every 32 clocks |
| pin_i | input | 1 | Raw asynchronous pin |
| level_o | output | 1 | Filtered level |
| rise_o | output | 1 | One-cycle strobe on a 0-to-1 change of level_o |
| fall_o | output | 1 | One-cycle strobe on a 1-to-0 change of level_o |

## Verification
Pulses of two samples, in both polarities and in every sampling mode, must leave the output alone. A filter that counted fewer agreeing samples, or that let the pin phase slip a sample in, would let them through. The latency in bypass mode and in the every-clock mode is measured to the exact edge, so an extra or a missing synchronizer stage shows up as a one-cycle shift, as does a misplaced output register. The select is switched after two samples that disagree with the output: a design that kept those stale samples would change the output on the first sample in the new mode, well before the three fresh samples that are required. A one-cycle pulse in bypass mode must pass, and both strobes must drop after a single cycle.

// File: rtl/pin_filt_pkg.sv
package pin_filt_pkg;

   typedef enum logic [1:0] {
      FSEL_BYPASS = 2'b00,
      FSEL_EVERY  = 2'b01,
      FSEL_MID    = 2'b10,
      FSEL_SLOW   = 2'b11
   } fsel_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/pf_sync.sv
module pf_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pf_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            chain_q[i] <= 1'b0;
         end else if (i == 0) begin
            chain_q[i] <= d_i;
         end else begin
            chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
         end
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pf_rate_gen.sv
module pf_rate_gen
   import pin_filt_pkg::*;
#(
   parameter int unsigned DIV_MID  = 8,
   parameter int unsigned DIV_SLOW = 32
) (
   input  logic  clk_i,
   input  logic  rst_ni,
   input  fsel_e sel_i,
   input  logic  clear_i,
   output logic  tick_o
);
   localparam int unsigned CW      = $clog2(DIV_SLOW);
   localparam int unsigned MID_LOG = $clog2(DIV_MID);
   localparam bit          POW2    = is_pow2(DIV_MID) && is_pow2(DIV_SLOW);
   localparam logic [CW-1:0] LIM_MID  = CW'(DIV_MID - 1);
   localparam logic [CW-1:0] LIM_SLOW = CW'(DIV_SLOW - 1);

   if (DIV_MID < 2) begin : g_bad_mid
      $error("pf_rate_gen: DIV_MID must be at least 2");
   end
   if (DIV_SLOW <= DIV_MID) begin : g_bad_slow
      $error("pf_rate_gen: DIV_SLOW must exceed DIV_MID");
   end

   logic [CW-1:0] cnt_q;
   logic          hit_mid, hit_slow;
   logic          divided;

   assign divided = (sel_i == FSEL_MID) || (sel_i == FSEL_SLOW);

   if (POW2) begin : g_mask
      // free-running counter: terminal count is read from the low bits
      assign hit_mid  = &cnt_q[MID_LOG-1:0];
      assign hit_slow = &cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            cnt_q <= '0;
         end else if (clear_i || !divided) begin
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end else begin : g_compare
      // arbitrary divisors: compare against the limit and wrap
      logic [CW-1:0] lim;
      assign lim      = (sel_i == FSEL_MID) ? LIM_MID : LIM_SLOW;
      assign hit_mid  = (cnt_q == LIM_MID);
      assign hit_slow = (cnt_q == LIM_SLOW);

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            cnt_q <= '0;
         end else if (clear_i || !divided || cnt_q == lim) begin
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   always_comb begin
      tick_o = 1'b0;
      if (!clear_i) begin
         unique case (sel_i)
            FSEL_EVERY:  tick_o = 1'b1;
            FSEL_MID:    tick_o = hit_mid;
            FSEL_SLOW:   tick_o = hit_slow;
            default:     tick_o = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/pf_vote.sv
module pf_vote #(
   parameter int unsigned AGREE = 3
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clear_i,
   input  logic bypass_i,
   input  logic tick_i,
   input  logic din_i,
   output logic level_o,
   output logic rise_o,
   output logic fall_o
);
   localparam int unsigned FW = $clog2(AGREE + 1);
   localparam logic [FW-1:0] FULL = FW'(AGREE);

   if (AGREE < 2) begin : g_bad_agree
      $error("pf_vote: AGREE must be at least 2");
   end

   logic [AGREE-1:0] hist_q, hist_n;
   logic [FW-1:0]    fill_q, fill_n;
   logic             agree, next_lvl;

   always_comb begin
      hist_n   = {hist_q[AGREE-2:0], din_i};
      fill_n   = (fill_q == FULL) ? FULL : fill_q + 1'b1;
      agree    = (fill_n == FULL) && ((&hist_n) || (~|hist_n));
      next_lvl = level_o;
      if (!clear_i) begin
         if (bypass_i) begin
            next_lvl = din_i;
         end else if (tick_i && agree) begin
            next_lvl = hist_n[0];
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         hist_q  <= '0;
         fill_q  <= '0;
         level_o <= 1'b0;
         rise_o  <= 1'b0;
         fall_o  <= 1'b0;
      end else begin
         if (clear_i || bypass_i) begin
            hist_q <= '0;
            fill_q <= '0;
         end else if (tick_i) begin
            hist_q <= hist_n;
            fill_q <= fill_n;
         end
         level_o <= next_lvl;
         rise_o  <= next_lvl & ~level_o;
         fall_o  <= ~next_lvl & level_o;
      end
   end
endmodule

// File: rtl/pin_glitch_filter.sv
module pin_glitch_filter
   import pin_filt_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned AGREE       = 3,
   parameter int unsigned DIV_MID     = 8,
   parameter int unsigned DIV_SLOW    = 32
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic [1:0] rate_sel_i,
   input  logic       pin_i,
   output logic       level_o,
   output logic       rise_o,
   output logic       fall_o
);
   logic [1:0] sel_q;
   logic       sel_chg;
   logic       pin_sync;
   logic       samp_tick;

   assign sel_chg = (rate_sel_i != sel_q);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sel_q <= 2'b00;
      end else begin
         sel_q <= rate_sel_i;
      end
   end

   pf_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (pin_i),
      .q_o    (pin_sync)
   );

   pf_rate_gen #(.DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)) u_rate (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sel_i   (fsel_e'(sel_q)),
      .clear_i (sel_chg),
      .tick_o  (samp_tick)
   );

   pf_vote #(.AGREE(AGREE)) u_vote (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clear_i  (sel_chg),
      .bypass_i (sel_q == FSEL_BYPASS),
      .tick_i   (samp_tick),
      .din_i    (pin_sync),
      .level_o  (level_o),
      .rise_o   (rise_o),
      .fall_o   (fall_o)
   );
endmodule

// File: rtl/pin_glitch_filter_chk.sv
module pin_glitch_filter_chk #(
   parameter int unsigned DIV_MID  = 8,
   parameter int unsigned DIV_SLOW = 32
) (
   input logic       clk_i,
   input logic       rst_ni,
   input logic [1:0] rate_sel_i,
   input logic [1:0] sel_q,
   input logic       tick,
   input logic       din,
   input logic       level_o,
   input logic       rise_o,
   input logic       fall_o
);
   logic [31:0] gap_q;
   logic        chg;
   assign chg = (rate_sel_i != sel_q);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) gap_q <= '0;
      else if (chg || tick) gap_q <= '0;
      else gap_q <= gap_q + 1;
   end

   always @(posedge clk_i) begin
      if (!rst_ni) begin
         a_r8_reset_clear: assert (!level_o && !rise_o && !fall_o);
      end
   end

   a_r2_bypass_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_q == 2'b00 && !chg) |=> (level_o == $past(din)));

   a_r3_every_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_q == 2'b01 && !chg) |-> tick);

   a_r4_mid_cadence: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_q == 2'b10 && !chg) |-> (tick == (gap_q == DIV_MID - 1)));

   a_r5_slow_cadence: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_q == 2'b11 && !chg) |-> (tick == (gap_q == DIV_SLOW - 1)));

   a_r6_new_value_sampled: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!$stable(level_o) && $past(sel_q) != 2'b00) |-> (level_o == $past(din)));

   a_r7_no_double_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(rise_o && fall_o));

   a_r7_rise_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(level_o) |-> rise_o);

   a_r7_fall_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(level_o) |-> fall_o);

   a_r7_rise_only_on_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o |=> !rise_o);

   a_r9_hold_on_switch: assert property (@(posedge clk_i) disable iff (!rst_ni)
      chg |=> $stable(level_o));

   a_r10_change_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_q != 2'b00 && !tick) |=> $stable(level_o));
endmodule

bind pin_glitch_filter pin_glitch_filter_chk #(.DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .rate_sel_i (rate_sel_i),
   .sel_q      (sel_q),
   .tick       (samp_tick),
   .din        (pin_sync),
   .level_o    (level_o),
   .rise_o     (rise_o),
   .fall_o     (fall_o)
);

// File: tb/pin_glitch_filter_tb.sv
`timescale 1ns/1ps
module pin_glitch_filter_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] sel = 2'b00;
   logic       pin = 1'b0;
   logic       level, rise, fall;
   int         checks = 0;
   int         errors = 0;
   bit         done = 1'b0;

   always #2 clk = ~clk;

   pin_glitch_filter u_dut (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .rate_sel_i (sel),
      .pin_i      (pin),
      .level_o    (level),
      .rise_o     (rise),
      .fall_o     (fall)
   );

   typedef struct packed {
      logic [1:0] sel;
      logic       pin;
      logic [7:0] hold;
      logic       exp;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VECS [NV] = '{
      '{2'b01, 1'b1, 8'd10,  1'b1},  // R3 steady high
      '{2'b01, 1'b0, 8'd2,   1'b1},  // R6 two-sample low pulse
      '{2'b01, 1'b1, 8'd10,  1'b1},  // R6 pulse was ignored
      '{2'b01, 1'b0, 8'd10,  1'b0},  // R3 steady low
      '{2'b10, 1'b1, 8'd16,  1'b0},  // R4 R6 high for two mid periods
      '{2'b10, 1'b0, 8'd40,  1'b0},  // R6 pulse was ignored
      '{2'b10, 1'b1, 8'd40,  1'b1},  // R4 steady high
      '{2'b10, 1'b0, 8'd16,  1'b1},  // R6 low for two mid periods
      '{2'b10, 1'b1, 8'd40,  1'b1},  // R6 pulse was ignored
      '{2'b11, 1'b0, 8'd64,  1'b1},  // R5 only one slow sample so far
      '{2'b11, 1'b0, 8'd80,  1'b0},  // R5 third slow sample taken
      '{2'b11, 1'b1, 8'd120, 1'b1},  // R5 steady high
      '{2'b00, 1'b0, 8'd4,   1'b0},  // R2 bypass low
      '{2'b00, 1'b1, 8'd4,   1'b1}   // R2 bypass high
   };

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic chk_lvl(input string req, input logic exp);
      check(level === exp, req, int'(level), int'(exp));
   endtask

   initial begin
      // R8 reset state
      step(3);
      check(level === 1'b0, "R8 level in reset", int'(level), 0);
      check(rise === 1'b0 && fall === 1'b0, "R8 strobes in reset", int'({rise, fall}), 0);
      rst_n = 1'b1;
      step(4);
      chk_lvl("R8 level after reset", 1'b0);

      // table walk
      for (int i = 0; i < NV; i++) begin
         sel = VECS[i].sel;
         pin = VECS[i].pin;
         step(int'(VECS[i].hold));
         chk_lvl($sformatf("R2-6 vector %0d", i), VECS[i].exp);
      end

      // R1 R2 bypass latency, pin high before
      pin = 1'b0;
      step(2);
      chk_lvl("R1 level before third edge", 1'b1);
      step(1);
      chk_lvl("R1 level on third edge", 1'b0);
      check(fall === 1'b1, "R7 fall strobe", int'(fall), 1);
      step(1);
      check(fall === 1'b0, "R7 fall strobe one cycle", int'(fall), 0);

      // R2 single-cycle pulse passes in bypass
      pin = 1'b1;
      step(1);
      pin = 1'b0;
      step(2);
      chk_lvl("R2 one-cycle pulse", 1'b1);
      check(rise === 1'b1, "R7 rise strobe", int'(rise), 1);
      step(1);
      chk_lvl("R2 pulse ends", 1'b0);
      check(rise === 1'b0, "R7 rise strobe one cycle", int'(rise), 0);
      step(4);

      // R3 latency in every-clock mode
      sel = 2'b01;
      step(5);
      pin = 1'b1;
      step(4);
      chk_lvl("R3 level before fifth edge", 1'b0);
      step(1);
      chk_lvl("R3 level on fifth edge", 1'b1);
      check(rise === 1'b1, "R7 rise on R3 change", int'(rise), 1);
      step(1);
      check(rise === 1'b0 && fall === 1'b0, "R7 strobes quiet", int'({rise, fall}), 0);

      // R9 stale samples discarded on select change
      pin = 1'b0;
      step(4);
      sel = 2'b10;
      step(14);
      chk_lvl("R9 history cleared on switch", 1'b1);
      step(26);
      chk_lvl("R9 fresh samples settle", 1'b0);

      // R8 reset drops a high level
      pin = 1'b1;
      step(40);
      chk_lvl("R4 high before reset", 1'b1);
      rst_n = 1'b0;
      step(1);
      chk_lvl("R8 reset clears level", 1'b0);
      check(rise === 1'b0 && fall === 1'b0, "R8 reset clears strobes", int'({rise, fall}), 0);
      rst_n = 1'b1;
      step(2);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(4ns * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule